// File: doc/BRIEF.md
# Indirect Address Generation Unit

This block forms the 16-bit data address for an indirect memory access and, in the same cycle, the value to write back into the pointer register. The caller supplies the pointer's current contents and its index in the 16-entry register file, a 3-bit addressing-mode code, a byte/word size flag, a 16-bit immediate, and a select that picks one of two offset registers. The block returns the effective address, the updated pointer value and a write-back enable.

The pointer can be left unchanged, or stepped by the access size. A displacement can be added to it. It can also be post-modified by a programmable offset. The two offset registers live inside the block. They have a clocked write port and a combinational read port. Bit 0 of each offset register is held at zero, so the offset is always an even word distance. All arithmetic wraps at 16 bits.

Top module: `ptr_agen`

## Requirements
- R1: Mode 0 (plain) gives `ea` = pointer and `ptr_next` = pointer with `ptr_we` = 0.
- R2: Mode 1 (post-increment) gives `ea` = pointer and `ptr_next` = pointer + 2 for a word access (`size_byte`=0) or + 1 for a byte access, with `ptr_we` = 1.
- R3: Mode 2 (pre-decrement) gives `ea` = `ptr_next` = pointer − 2 for a word access or − 1 for a byte access, with `ptr_we` = 1.
- R4: Mode 3 (displacement) gives `ea` = pointer + `imm` and `ptr_next` = pointer with `ptr_we` = 0.
- R5: Mode 4 (post-decrement, word only) gives `ea` = pointer and `ptr_next` = pointer − 2, with `ptr_we` = 1.
- R6: Modes 5 and 6 (offset post-add and offset post-subtract, word only) give `ea` = pointer and `ptr_next` = pointer plus or minus the offset register chosen by `ofs_sel`, with `ptr_we` = 1.
- R7: Both offset registers read 0x0000 after reset. Bit 0 always reads 0, whatever value is written to it.
- R8: An offset write takes effect at the clock edge where `ofs_we` = 1. A computation in that same cycle uses the old offset value.
- R9: When `restrict_ptr` = 1 and `ptr_idx` > 3, `err_ptr` = 1, `ptr_we` = 0 and `ptr_next` = pointer. When `restrict_ptr` = 0, any index is accepted.
- R10: A byte access (`size_byte`=1) in mode 4, 5 or 6 raises `err_mode`. Mode code 7 also raises `err_mode`. In both cases `ptr_we` = 0, `ptr_next` = pointer and `ea` = pointer.
- R11: All address and pointer arithmetic wraps modulo 2^16.
- R12: `ea`, `ptr_next`, `ptr_we` and both error flags are combinational and valid in the same cycle as the inputs. Whenever `ptr_we` = 0, `ptr_next` equals the input pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the offset registers |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Addressing-mode code (0..7) |
| size_byte | input | 1 | 1 = byte access, 0 = word access |
| ptr_idx | input | 4 | Register-file index of the pointer |
| ptr_val | input | 16 | Current pointer contents |
| restrict_ptr | input | 1 | Only pointers 0..3 allowed |
| imm | input | 16 | Displacement for mode 3 |
| ofs_sel | input | 1 | Offset register used by modes 5/6 |
| ofs_we | input | 1 | Offset register write enable |
| ofs_wsel | input | 1 | Offset register to write |
| ofs_wdata | input | 16 | Offset write data (bit 0 ignored) |
| ofs_rsel | input | 1 | Offset register to read |
| ofs_rdata | output | 16 | Offset register read data |
| ea | output | 16 | Effective address |
| ptr_next | output | 16 | Pointer value to write back |
| ptr_we | output | 1 | Pointer write-back enable |
| err_mode | output | 1 | Illegal mode/size combination |
| err_ptr | output | 1 | Illegal pointer index under restriction |

## Verification
The hardest case to set up from the ports is a cycle where an offset register is being written while an offset post-modify computation reads the same register. The bench holds `ofs_we` high with a new value and drives mode 5 in the same low clock phase. It checks that `ptr_next` still uses the old offset before the edge, and then checks that the new offset is used after the edge. Wrap-around needs chosen pointer values near 0x0000 and 0xFFFF, and these are placed in the vector table.

// File: rtl/ptr_agen_pkg.sv
// Package: shared mode codes for the indirect address generator.
// Assumes a 3-bit mode field; code 7 is reserved and treated as illegal.
package ptr_agen_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_DISP    = 3'd3,
        AM_POSTDEC = 3'd4,
        AM_OFSADD  = 3'd5,
        AM_OFSSUB  = 3'd6,
        AM_RSVD    = 3'd7
    } am_e;
endpackage

// File: rtl/ptr_agen_ofs_bank.sv
// Module: bank of NOFS offset registers.
// Each register stores only bits AW-1:1; bit 0 reads as zero.
// Write is synchronous. The two read ports are combinational and show
// the value from before any write in the same cycle.
module ptr_agen_ofs_bank #(
    parameter int AW   = 16,
    parameter int NOFS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NOFS)-1:0] wsel,
    input  logic [AW-1:0]           wdata,
    input  logic [$clog2(NOFS)-1:0] rsel_a,
    output logic [AW-1:0]           rdata_a,
    input  logic [$clog2(NOFS)-1:0] rsel_b,
    output logic [AW-1:0]           rdata_b
);
    logic [AW-1:1] store [NOFS];

    for (genvar g = 0; g < NOFS; g++) begin : g_reg
        // Purpose: reset or load one offset register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (we && wsel == g)
                store[g] <= wdata[AW-1:1];
        end
    end

    // Purpose: combinational reads with forced-zero LSB.
    always_comb begin
        rdata_a = {store[rsel_a], 1'b0};
        rdata_b = {store[rsel_b], 1'b0};
    end
endmodule

// File: rtl/ptr_agen_step.sv
// Module: decodes the mode into a two's-complement pointer delta and control flags.
// Assumes the offset value is already selected. It does no error masking.
module ptr_agen_step
    import ptr_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  am_e           mode,
    input  logic          size_byte,
    input  logic [AW-1:0] ofs_val,
    output logic [AW-1:0] delta,
    output logic          pre,
    output logic          disp,
    output logic          upd,
    output logic          word_only,
    output logic          rsvd
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] unit;

    // Purpose: access-size step, 1 for bytes and 2 for words.
    always_comb unit = size_byte ? ONE : TWO;

    // Purpose: per-mode delta and flags.
    always_comb begin
        delta = '0; pre = 1'b0; disp = 1'b0; upd = 1'b0;
        word_only = 1'b0; rsvd = 1'b0;
        unique case (mode)
            AM_PLAIN:   ;
            AM_POSTINC: begin delta = unit;        upd = 1'b1; end
            AM_PREDEC:  begin delta = -unit;       upd = 1'b1; pre = 1'b1; end
            AM_DISP:    disp = 1'b1;
            AM_POSTDEC: begin delta = -TWO;        upd = 1'b1; word_only = 1'b1; end
            AM_OFSADD:  begin delta = ofs_val;     upd = 1'b1; word_only = 1'b1; end
            AM_OFSSUB:  begin delta = -ofs_val;    upd = 1'b1; word_only = 1'b1; end
            default:    rsvd = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptr_agen.sv
// Module: indirect address generator top.
// Forms the effective address and the write-back pointer combinationally.
// Holds the offset registers. Arithmetic wraps at AW bits.
// Assumes the caller gates the real pointer write with ptr_we.
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NOFS  = 2,
    parameter int IDXW  = 4,
    parameter int NLOW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic                    size_byte,
    input  logic [IDXW-1:0]         ptr_idx,
    input  logic [AW-1:0]           ptr_val,
    input  logic                    restrict_ptr,
    input  logic [AW-1:0]           imm,
    input  logic [$clog2(NOFS)-1:0] ofs_sel,
    input  logic                    ofs_we,
    input  logic [$clog2(NOFS)-1:0] ofs_wsel,
    input  logic [AW-1:0]           ofs_wdata,
    input  logic [$clog2(NOFS)-1:0] ofs_rsel,
    output logic [AW-1:0]           ofs_rdata,
    output logic [AW-1:0]           ea,
    output logic [AW-1:0]           ptr_next,
    output logic                    ptr_we,
    output logic                    err_mode,
    output logic                    err_ptr
);
    localparam logic [IDXW-1:0] LOW_MAX = IDXW'(NLOW - 1);

    logic [AW-1:0] ofs_val, delta, stepped;
    logic          pre, disp, upd, word_only, rsvd;

    ptr_agen_ofs_bank #(.AW(AW), .NOFS(NOFS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(ofs_we), .wsel(ofs_wsel),
        .wdata(ofs_wdata), .rsel_a(ofs_sel), .rdata_a(ofs_val),
        .rsel_b(ofs_rsel), .rdata_b(ofs_rdata)
    );

    ptr_agen_step #(.AW(AW)) u_step (
        .mode(am_e'(mode)), .size_byte(size_byte), .ofs_val(ofs_val),
        .delta(delta), .pre(pre), .disp(disp), .upd(upd),
        .word_only(word_only), .rsvd(rsvd)
    );

    // Purpose: error flags for an illegal size and an illegal pointer index.
    always_comb begin
        err_mode = rsvd | (word_only & size_byte);
        err_ptr  = restrict_ptr & (ptr_idx > LOW_MAX);
    end

    // Purpose: wrapped arithmetic, address select and write-back gating.
    always_comb begin
        stepped  = ptr_val + delta;
        ptr_we   = upd & ~err_mode & ~err_ptr;
        ptr_next = ptr_we ? stepped : ptr_val;
        if (disp)
            ea = ptr_val + imm;
        else if (pre && !err_mode)
            ea = stepped;
        else
            ea = ptr_val;
    end
endmodule

// File: rtl/ptr_agen_chk.sv
// Module: assertion checker for ptr_agen, attached with bind.
// It only observes the ports.
module ptr_agen_chk #(
    parameter int AW   = 16,
    parameter int NOFS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              mode,
    input logic                    ofs_we,
    input logic [$clog2(NOFS)-1:0] ofs_rsel,
    input logic [AW-1:0]           ofs_rdata,
    input logic [AW-1:0]           ptr_val,
    input logic [AW-1:0]           ea,
    input logic [AW-1:0]           ptr_next,
    input logic                    ptr_we,
    input logic                    err_mode,
    input logic                    err_ptr
);
    p_plain_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd0 |-> (ea == ptr_val && !ptr_we));
    p_post_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 || mode == 3'd4 || mode == 3'd5 || mode == 3'd6) |-> ea == ptr_val);
    p_predec_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && ptr_we) |-> ea == ptr_next);
    p_disp_nowb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd3 |-> !ptr_we);
    p_lsb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_rdata[0] == 1'b0);
    p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ofs_we) && $stable(ofs_rsel)) |-> $stable(ofs_rdata));
    p_ptr_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_ptr |-> !ptr_we);
    p_mode_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> (!ptr_we && ea == ptr_val));
    p_nowb_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |-> ptr_next == ptr_val);
endmodule

bind ptr_agen ptr_agen_chk #(.AW(AW), .NOFS(NOFS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ofs_we(ofs_we),
    .ofs_rsel(ofs_rsel), .ofs_rdata(ofs_rdata), .ptr_val(ptr_val),
    .ea(ea), .ptr_next(ptr_next), .ptr_we(ptr_we),
    .err_mode(err_mode), .err_ptr(err_ptr)
);

// File: tb/tb_ptr_agen.sv
module tb_ptr_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic        size_byte = 1'b0;
    logic [3:0]  ptr_idx = 4'd5;
    logic [15:0] ptr_val = '0;
    logic        restrict_ptr = 1'b0;
    logic [15:0] imm = '0;
    logic        ofs_sel = 1'b0;
    logic        ofs_we = 1'b0;
    logic        ofs_wsel = 1'b0;
    logic [15:0] ofs_wdata = '0;
    logic        ofs_rsel = 1'b0;
    logic [15:0] ofs_rdata, ea, ptr_next;
    logic        ptr_we, err_mode, err_ptr;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    ptr_agen dut (.*);

    typedef struct packed {
        logic [2:0]  md;
        logic        byt;
        logic [15:0] p;
        logic [15:0] im;
        logic        os;
        logic [15:0] x_ea;
        logic [15:0] x_nx;
        logic        x_we;
        logic        x_em;
    } vec_t;

    // Offsets during the table: reg0 = 0x0102, reg1 = 0x0040
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 16'h1234, 16'h0000, 1'b0, 16'h1234, 16'h1234, 1'b0, 1'b0}, // R1
        '{3'd1, 1'b0, 16'h1234, 16'h0000, 1'b0, 16'h1234, 16'h1236, 1'b1, 1'b0}, // R2 word
        '{3'd1, 1'b1, 16'h1234, 16'h0000, 1'b0, 16'h1234, 16'h1235, 1'b1, 1'b0}, // R2 byte
        '{3'd1, 1'b0, 16'hFFFE, 16'h0000, 1'b0, 16'hFFFE, 16'h0000, 1'b1, 1'b0}, // R11 wrap
        '{3'd2, 1'b0, 16'h1234, 16'h0000, 1'b0, 16'h1232, 16'h1232, 1'b1, 1'b0}, // R3 word
        '{3'd2, 1'b1, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0}, // R3 R11
        '{3'd3, 1'b0, 16'h1000, 16'h0234, 1'b0, 16'h1234, 16'h1000, 1'b0, 1'b0}, // R4
        '{3'd3, 1'b1, 16'hFFF0, 16'h0020, 1'b0, 16'h0010, 16'hFFF0, 1'b0, 1'b0}, // R4 R11
        '{3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'hFFFE, 1'b1, 1'b0}, // R5
        '{3'd5, 1'b0, 16'h1000, 16'h0000, 1'b0, 16'h1000, 16'h1102, 1'b1, 1'b0}, // R6 add reg0
        '{3'd6, 1'b0, 16'h1000, 16'h0000, 1'b1, 16'h1000, 16'h0FC0, 1'b1, 1'b0}, // R6 sub reg1
        '{3'd5, 1'b0, 16'hFFE0, 16'h0000, 1'b1, 16'hFFE0, 16'h0020, 1'b1, 1'b0}, // R6 R11
        '{3'd4, 1'b1, 16'h2000, 16'h0000, 1'b0, 16'h2000, 16'h2000, 1'b0, 1'b1}, // R10
        '{3'd6, 1'b1, 16'h2000, 16'h0000, 1'b1, 16'h2000, 16'h2000, 1'b0, 1'b1}, // R10
        '{3'd7, 1'b0, 16'h3000, 16'h0000, 1'b0, 16'h3000, 16'h3000, 1'b0, 1'b1}  // R10 R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ofs(input logic s, input logic [15:0] d);
        @(negedge clk);
        ofs_we = 1'b1; ofs_wsel = s; ofs_wdata = d;
        @(negedge clk);
        ofs_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        ofs_rsel = 1'b0; #1; check("R7 reset reg0", ofs_rdata, 16'h0000);
        ofs_rsel = 1'b1; #1; check("R7 reset reg1", ofs_rdata, 16'h0000);

        wr_ofs(1'b0, 16'h0103);
        wr_ofs(1'b1, 16'h0041);
        ofs_rsel = 1'b0; #1; check("R7 bit0 reg0", ofs_rdata, 16'h0102);
        ofs_rsel = 1'b1; #1; check("R7 bit0 reg1", ofs_rdata, 16'h0040);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode = VECS[i].md; size_byte = VECS[i].byt; ptr_val = VECS[i].p;
            imm = VECS[i].im; ofs_sel = VECS[i].os;
            #1;
            check($sformatf("vec%0d ea", i), ea, VECS[i].x_ea);
            check($sformatf("vec%0d ptr_next", i), ptr_next, VECS[i].x_nx);
            check($sformatf("vec%0d ptr_we", i), ptr_we, VECS[i].x_we);
            check($sformatf("vec%0d err_mode", i), err_mode, VECS[i].x_em);
        end

        // R8: a same-cycle write does not affect the computation
        @(negedge clk);
        mode = 3'd5; size_byte = 1'b0; ptr_val = 16'h1000; ofs_sel = 1'b0;
        ofs_we = 1'b1; ofs_wsel = 1'b0; ofs_wdata = 16'h0010;
        #1; check("R8 old offset used", ptr_next, 16'h1102);
        @(negedge clk);
        ofs_we = 1'b0; #1;
        check("R8 new offset after edge", ptr_next, 16'h1010);

        // R9: restricted pointer index
        mode = 3'd1; ptr_val = 16'h0400; restrict_ptr = 1'b1; ptr_idx = 4'd4; #1;
        check("R9 err_ptr idx4", err_ptr, 1'b1);
        check("R9 no wb idx4", ptr_we, 1'b0);
        check("R9 ptr kept", ptr_next, 16'h0400);
        ptr_idx = 4'd3; #1;
        check("R9 idx3 ok", err_ptr, 1'b0);
        check("R9 idx3 wb", ptr_next, 16'h0402);
        restrict_ptr = 1'b0; ptr_idx = 4'd15; #1;
        check("R9 unrestricted idx15", {err_ptr, ptr_we}, 2'b01);

        // R12: outputs follow the inputs within the same cycle, with no clock edge
        ptr_val = 16'h0500; #1;
        check("R12 same-cycle update", ptr_next, 16'h0502);

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule